// File: doc/BRIEF.md
# Single-Precision Register Format Converter

This block moves 32-bit IEEE single-precision values between their memory image and a 64-bit register image. In the register image a single is kept in double-width layout: an 11-bit exponent field and a 52-bit fraction field, of which only the upper 23 fraction bits carry data. The load path widens a 32-bit word into this layout. The store path takes a 64-bit register value and picks out the bits that form the 32-bit memory word.

The exponent is widened by remapping its bits, with no change of bias arithmetic. The top exponent bit stays on top. The low seven bits stay at the bottom. The three new middle bits are filled so that zero stays zero and the all-ones code stays all-ones. A third path narrows a 64-bit integer to a 32-bit longword and places it in register layout with the same bit arrangement the store path reads back. It also flags the case where the integer does not fit in 32 signed bits.

Each of the three paths has one register stage. Each has its own valid input, and a matching valid output one clock later. The paths share a clock and a synchronous active-high reset, and otherwise do not interact.

Top module: `sp_regfmt_conv`

## Requirements
- R1: Load path: input bit 31 (sign) appears at output bit 63, input bits 22:0 (fraction) appear at output bits 51:29, and output bits 28:0 are zero.
- R2: Load path: the single exponent (input bits 30:23) is widened into output bits 62:52. Its top bit goes to bit 62 and its low seven bits go to bits 58:52. When the top bit is 1 and the low seven bits are not all ones, bits 61:59 are 000.
- R3: Load path: an input exponent of 0xFF gives a widened exponent of 0x7FF.
- R4: Load path: when the exponent top bit is 0 and the low seven bits are nonzero, bits 61:59 are 111. An input exponent of 0x00 gives a widened exponent of 0x000.
- R5: Store path: the 32-bit output takes register bits 63:62 as its bits 31:30 and register bits 58:29 as its bits 29:0. All other register bits have no effect on it.
- R6: Narrow path: integer bits 31:30 go to output bits 63:62 and integer bits 29:0 go to output bits 58:29. All other output bits are zero.
- R7: Narrow path: the integer-overflow flag and the inexact flag are both 1 exactly when the 64-bit input differs from the sign extension of its own bits 31:0. Otherwise both are 0.
- R8: Each path's valid output equals its valid input from one clock earlier. Activity on one path has no effect on the other paths.
- R9: Reset clears all three valid outputs, all data outputs and both flags to zero.
- R10: When a path's valid input is low, that path's data output (and, for the narrow path, its flags) keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_vld_i | input | 1 | Load request valid |
| ld_word_i | input | 32 | Single-precision memory word |
| ld_vld_o | output | 1 | Load result valid |
| ld_reg_o | output | 64 | Widened register image |
| st_vld_i | input | 1 | Store request valid |
| st_reg_i | input | 64 | Register image to store |
| st_vld_o | output | 1 | Store result valid |
| st_word_o | output | 32 | Memory word |
| nw_vld_i | input | 1 | Narrow request valid |
| nw_int_i | input | 64 | 64-bit integer to narrow |
| nw_vld_o | output | 1 | Narrow result valid |
| nw_reg_o | output | 64 | Longword in register layout |
| nw_iov_o | output | 1 | Integer overflow flag |
| nw_ine_o | output | 1 | Inexact flag |

## Verification
The bench builds the block with the package's default geometry: a 32-bit single with an 8-bit exponent and 23-bit fraction, and a 64-bit register with an 11-bit exponent. At these values the four exponent classes can all be reached with a handful of words: zero, the 0x01..0x7F range, the 0x80..0xFE range, and the all-ones code. The longword boundary values are the positive and negative 32-bit limits and the values just past them, and these are the points where the overflow flag changes. Store words are also fed with noise in the unused register bits, so that any leak from those bits shows up in the output.

// File: rtl/sregfmt_pkg.sv
package sregfmt_pkg;

    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int REG_W     = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;

    localparam int LO_EXP_W  = SP_EXP_W - 1;
    localparam int FILL_W    = DP_EXP_W - SP_EXP_W;
    localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;
    localparam int LW_HI_W   = 2;
    localparam int LW_LO_W   = SP_W - LW_HI_W;
    localparam int LW_GAP_W  = REG_W - LW_HI_W - LW_LO_W - FRAC_PAD;
    localparam int FLAG_W    = 2;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_word_t;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
    } reg_word_t;

    typedef struct packed {
        logic iov;
        logic ine;
    } lw_flags_t;

    typedef enum logic [1:0] {
        EXP_ZERO    = 2'd0,
        EXP_LOW     = 2'd1,
        EXP_HIGH    = 2'd2,
        EXP_SPECIAL = 2'd3
    } exp_class_t;

    function automatic exp_class_t classify_exp(input logic [SP_EXP_W-1:0] e);
        exp_class_t c;
        if (e[SP_EXP_W-1]) begin
            c = (e[LO_EXP_W-1:0] == {LO_EXP_W{1'b1}}) ? EXP_SPECIAL : EXP_HIGH;
        end else begin
            c = (e[LO_EXP_W-1:0] == '0) ? EXP_ZERO : EXP_LOW;
        end
        return c;
    endfunction

    function automatic logic [DP_EXP_W-1:0] widen_exp(input logic [SP_EXP_W-1:0] e);
        logic [DP_EXP_W-1:0] w;
        unique case (classify_exp(e))
            EXP_ZERO:    w = '0;
            EXP_SPECIAL: w = '1;
            EXP_LOW:     w = {1'b0, {FILL_W{1'b1}}, e[LO_EXP_W-1:0]};
            default:     w = {1'b1, {FILL_W{1'b0}}, e[LO_EXP_W-1:0]};
        endcase
        return w;
    endfunction

    function automatic reg_word_t expand_single(input sp_word_t s);
        reg_word_t r;
        r.sign = s.sign;
        r.exp  = widen_exp(s.exp);
        r.frac = {s.frac, {FRAC_PAD{1'b0}}};
        return r;
    endfunction

    function automatic logic [SP_W-1:0] pack_store(input logic [REG_W-1:0] r);
        return {r[REG_W-1 -: LW_HI_W], r[FRAC_PAD+LW_LO_W-1 -: LW_LO_W]};
    endfunction

    function automatic logic [REG_W-1:0] pack_longword(input logic [REG_W-1:0] v);
        return {v[SP_W-1 -: LW_HI_W], {LW_GAP_W{1'b0}}, v[LW_LO_W-1:0], {FRAC_PAD{1'b0}}};
    endfunction

    function automatic lw_flags_t lw_check(input logic [REG_W-1:0] v);
        lw_flags_t f;
        logic      ovf;
        ovf   = (v != {{(REG_W-SP_W){v[SP_W-1]}}, v[SP_W-1:0]});
        f.iov = ovf;
        f.ine = ovf;
        return f;
    endfunction

endpackage

// File: rtl/conv_stage.sv
module conv_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] data_i,
    output logic         vld_o,
    output logic [W-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            data_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                data_o <= data_i;
            end
        end
    end

    p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(data_o));

endmodule

// File: rtl/sp_load_path.sv
module sp_load_path
    import sregfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [SP_W-1:0]  word_i,
    output logic             vld_o,
    output logic [REG_W-1:0] reg_o
);

    sp_word_t  in_w;
    reg_word_t wide;

    always_comb begin
        in_w = sp_word_t'(word_i);
        wide = expand_single(in_w);
    end

    conv_stage #(.W(REG_W)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld_i),
        .data_i (wide),
        .vld_o  (vld_o),
        .data_o (reg_o)
    );

    reg_word_t out_w;
    assign out_w = reg_word_t'(reg_o);

    p_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> out_w.frac[FRAC_PAD-1:0] == '0);
    p_fill_r4: assert property (@(posedge clk) disable iff (rst)
        vld_o && !out_w.exp[DP_EXP_W-1] && out_w.exp != '0
            |-> out_w.exp[DP_EXP_W-2 -: FILL_W] == {FILL_W{1'b1}});
    p_special_r3: assert property (@(posedge clk) disable iff (rst)
        vld_o && out_w.exp[DP_EXP_W-1] && out_w.exp[DP_EXP_W-2 -: FILL_W] != '0
            |-> out_w.exp == '1);
    p_sign_r1: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> out_w.sign == $past(word_i[SP_W-1]));

endmodule

// File: rtl/sp_store_path.sv
module sp_store_path
    import sregfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [REG_W-1:0] reg_i,
    output logic             vld_o,
    output logic [SP_W-1:0]  word_o
);

    logic [SP_W-1:0] packed_w;

    always_comb begin
        packed_w = pack_store(reg_i);
    end

    conv_stage #(.W(SP_W)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld_i),
        .data_i (packed_w),
        .vld_o  (vld_o),
        .data_o (word_o)
    );

    p_store_hi_r5: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> word_o[SP_W-1 -: LW_HI_W] == $past(reg_i[REG_W-1 -: LW_HI_W]));
    p_store_lo_r5: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> word_o[LW_LO_W-1:0] == $past(reg_i[FRAC_PAD+LW_LO_W-1 -: LW_LO_W]));

endmodule

// File: rtl/lw_narrow_path.sv
module lw_narrow_path
    import sregfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [REG_W-1:0] int_i,
    output logic             vld_o,
    output logic [REG_W-1:0] reg_o,
    output logic             iov_o,
    output logic             ine_o
);

    localparam int STG_W = REG_W + FLAG_W;

    lw_flags_t        flags_d;
    lw_flags_t        flags_q;
    logic [STG_W-1:0] stage_d;
    logic [STG_W-1:0] stage_q;

    always_comb begin
        flags_d = lw_check(int_i);
        stage_d = {pack_longword(int_i), flags_d};
    end

    conv_stage #(.W(STG_W)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld_i),
        .data_i (stage_d),
        .vld_o  (vld_o),
        .data_o (stage_q)
    );

    assign reg_o   = stage_q[STG_W-1 -: REG_W];
    assign flags_q = lw_flags_t'(stage_q[FLAG_W-1:0]);
    assign iov_o   = flags_q.iov;
    assign ine_o   = flags_q.ine;

    p_flags_pair_r7: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> iov_o == ine_o);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        vld_i && int_i[REG_W-1:SP_W-1] == '0 |=> !iov_o);
    p_gaps_r6: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> reg_o[FRAC_PAD-1:0] == '0
               && reg_o[REG_W-LW_HI_W-1 -: LW_GAP_W] == '0);

endmodule

// File: rtl/sp_regfmt_conv.sv
module sp_regfmt_conv
    import sregfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_vld_i,
    input  logic [SP_W-1:0]   ld_word_i,
    output logic              ld_vld_o,
    output logic [REG_W-1:0]  ld_reg_o,
    input  logic              st_vld_i,
    input  logic [REG_W-1:0]  st_reg_i,
    output logic              st_vld_o,
    output logic [SP_W-1:0]   st_word_o,
    input  logic              nw_vld_i,
    input  logic [REG_W-1:0]  nw_int_i,
    output logic              nw_vld_o,
    output logic [REG_W-1:0]  nw_reg_o,
    output logic              nw_iov_o,
    output logic              nw_ine_o
);

    sp_load_path u_load (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (ld_vld_i),
        .word_i (ld_word_i),
        .vld_o  (ld_vld_o),
        .reg_o  (ld_reg_o)
    );

    sp_store_path u_store (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (st_vld_i),
        .reg_i  (st_reg_i),
        .vld_o  (st_vld_o),
        .word_o (st_word_o)
    );

    lw_narrow_path u_narrow (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (nw_vld_i),
        .int_i  (nw_int_i),
        .vld_o  (nw_vld_o),
        .reg_o  (nw_reg_o),
        .iov_o  (nw_iov_o),
        .ine_o  (nw_ine_o)
    );

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> !ld_vld_o && !st_vld_o && !nw_vld_o);

endmodule

// File: tb/test_sp_regfmt_conv.sv
`timescale 1ns/1ps
module test_sp_regfmt_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_vld_i = 1'b0;
    logic [31:0] ld_word_i = '0;
    logic        ld_vld_o;
    logic [63:0] ld_reg_o;
    logic        st_vld_i = 1'b0;
    logic [63:0] st_reg_i = '0;
    logic        st_vld_o;
    logic [31:0] st_word_o;
    logic        nw_vld_i = 1'b0;
    logic [63:0] nw_int_i = '0;
    logic        nw_vld_o;
    logic [63:0] nw_reg_o;
    logic        nw_iov_o;
    logic        nw_ine_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    logic [63:0] ld_q[$];
    logic [31:0] st_q[$];
    logic [65:0] nw_q[$];

    always #2.5 clk = ~clk;

    sp_regfmt_conv i_sp_regfmt_conv (
        .clk(clk), .rst(rst),
        .ld_vld_i(ld_vld_i), .ld_word_i(ld_word_i), .ld_vld_o(ld_vld_o), .ld_reg_o(ld_reg_o),
        .st_vld_i(st_vld_i), .st_reg_i(st_reg_i), .st_vld_o(st_vld_o), .st_word_o(st_word_o),
        .nw_vld_i(nw_vld_i), .nw_int_i(nw_int_i), .nw_vld_o(nw_vld_o), .nw_reg_o(nw_reg_o),
        .nw_iov_o(nw_iov_o), .nw_ine_o(nw_ine_o)
    );

    task automatic check(input logic ok, input string req, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected values, built from the requirement text.
    function automatic logic [63:0] model_load(input logic [31:0] w);
        logic [10:0] e;
        logic        top;
        logic [6:0]  lo;
        top = w[30];
        lo  = w[29:23];
        if (top && lo == 7'h7F)       e = 11'h7FF;          // R3
        else if (top)                 e = {4'b1000, lo};    // R2
        else if (lo != 7'h00)         e = {4'b0111, lo};    // R4
        else                          e = 11'h000;          // R4
        return {w[31], e, w[22:0], 29'h0};                  // R1
    endfunction

    function automatic logic [31:0] model_store(input logic [63:0] r);
        return {r[63:62], r[58:29]};                        // R5
    endfunction

    function automatic logic [65:0] model_narrow(input logic [63:0] v);
        logic ovf;
        ovf = ($signed(v) > 64'sh7FFFFFFF) || ($signed(v) < -64'sh80000000); // R7
        return {v[31:30], 3'b000, v[29:0], 29'h0, ovf, ovf}; // R6
    endfunction

    function automatic logic [63:0] next_rng(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic put_load(input logic [31:0] w);
        ld_vld_i = 1'b1; ld_word_i = w; ld_q.push_back(model_load(w));
    endtask
    task automatic put_store(input logic [63:0] r);
        st_vld_i = 1'b1; st_reg_i = r; st_q.push_back(model_store(r));
    endtask
    task automatic put_narrow(input logic [63:0] v);
        nw_vld_i = 1'b1; nw_int_i = v; nw_q.push_back(model_narrow(v));
    endtask
    task automatic tick();
        @(posedge clk); #1;
        ld_vld_i = 1'b0; st_vld_i = 1'b0; nw_vld_i = 1'b0;
    endtask

    // Monitor / scoreboard (R8: an output valid with nothing pending fails)
    always @(negedge clk) begin
        if (!rst) begin
            if (ld_vld_o) begin
                if (ld_q.size() == 0) check(1'b0, "R8 load extra valid", 66'(ld_reg_o), 66'h0);
                else begin
                    logic [63:0] e;
                    e = ld_q.pop_front();
                    check(ld_reg_o == e, "R1 R2 R3 R4 load", 66'(ld_reg_o), 66'(e));
                end
            end
            if (st_vld_o) begin
                if (st_q.size() == 0) check(1'b0, "R8 store extra valid", 66'(st_word_o), 66'h0);
                else begin
                    logic [31:0] e;
                    e = st_q.pop_front();
                    check(st_word_o == e, "R5 store", 66'(st_word_o), 66'(e));
                end
            end
            if (nw_vld_o) begin
                if (nw_q.size() == 0) check(1'b0, "R8 narrow extra valid", 66'(nw_reg_o), 66'h0);
                else begin
                    logic [65:0] e;
                    e = nw_q.pop_front();
                    check({nw_reg_o, nw_iov_o, nw_ine_o} == e, "R6 R7 narrow",
                          {nw_reg_o, nw_iov_o, nw_ine_o}, e);
                end
            end
        end
    end

    bit done = 0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check_reset_state(input string req);
        check({ld_vld_o, st_vld_o, nw_vld_o} == 3'b000, req, 66'({ld_vld_o, st_vld_o, nw_vld_o}), 66'h0);
        check(ld_reg_o == '0 && st_word_o == '0, req, 66'(ld_reg_o | 64'(st_word_o)), 66'h0);
        check(nw_reg_o == '0 && !nw_iov_o && !nw_ine_o, req,
              {nw_reg_o, nw_iov_o, nw_ine_o}, 66'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("R9 reset");
        rst = 1'b0;
        tick();

        // R1 R2 R3 R4: each exponent class, one per cycle
        put_load(32'h3F800000); tick();   // low class, 0x7F -> 0x3FF
        put_load(32'h7F800000); tick();   // R3 infinity
        put_load(32'h7FC00001); tick();   // R3 NaN
        put_load(32'h00000001); tick();   // R4 zero exponent, fraction kept
        put_load(32'h80000000); tick();   // R1 negative zero
        put_load(32'hC0000000); tick();   // R2 high class, 0x80
        put_load(32'h7F7FFFFF); tick();   // R2 largest finite
        put_load(32'h00800000); tick();   // R4 smallest normal
        put_load(32'hBF000000);           // back-to-back
        tick();
        put_load(32'h40490FDB); tick();
        tick(); tick();
        // R10: load output holds while idle
        check(ld_reg_o == model_load(32'h40490FDB), "R10 load hold",
              66'(ld_reg_o), 66'(model_load(32'h40490FDB)));

        // R5: store, including noise in the ignored bits 61:59 and 28:0
        put_store(64'h3FF0000000000000); tick();
        put_store(64'hC000000000000000); tick();
        put_store(64'h3800000000000000 | 64'h1FFFFFFF); tick();
        for (int i = 0; i < 40; i++) begin
            rng = next_rng(rng);
            put_store(rng);
            tick();
        end
        tick(); tick();
        check(st_word_o == model_store(rng), "R10 store hold",
              66'(st_word_o), 66'(model_store(rng)));

        // R6 R7: longword boundaries
        put_narrow(64'h000000007FFFFFFF); tick();
        put_narrow(64'h0000000080000000); tick();
        put_narrow(64'hFFFFFFFF80000000); tick();
        put_narrow(64'hFFFFFFFF7FFFFFFF); tick();
        put_narrow(64'hFFFFFFFFFFFFFFFF); tick();
        put_narrow(64'h0000000100000000); tick();
        put_narrow(64'h0000000000000000); tick();
        put_narrow(64'h123456789ABCDEF0); tick();
        tick(); tick();
        check({nw_reg_o, nw_iov_o, nw_ine_o} == model_narrow(64'h123456789ABCDEF0), "R10 narrow hold",
              {nw_reg_o, nw_iov_o, nw_ine_o}, model_narrow(64'h123456789ABCDEF0));

        // R8: paths run together and separately in a mixed pattern
        for (int i = 0; i < 60; i++) begin
            rng = next_rng(rng);
            if (rng[0]) put_load(rng[63:32]);
            if (rng[1]) put_store(rng);
            if (rng[2]) put_narrow({{32{rng[3]}}, rng[31:0]} ^ (rng[4] ? 64'h1_0000_0000 : 64'h0));
            tick();
        end
        tick(); tick();
        check(ld_q.size() == 0 && st_q.size() == 0 && nw_q.size() == 0, "R8 all results returned",
              66'(ld_q.size() + st_q.size() + nw_q.size()), 66'h0);

        // R9: reset in the middle of operation
        put_load(32'h3F800000); put_store(64'hFFFFFFFFFFFFFFFF); put_narrow(64'h0000000080000000);
        tick();
        ld_q.delete(); st_q.delete(); nw_q.delete();
        rst = 1'b1;
        @(posedge clk); #1;
        check_reset_state("R9 mid-run reset");
        rst = 1'b0;
        tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule